// File: doc/BRIEF.md
# ATM Cell Header Error Checker

This block sits on a byte-wide ATM cell stream whose cell boundaries are already known. For every cell it recomputes the header check octet from the four leading header octets and compares it with the fifth octet received. If they differ, the block either repairs a single flipped bit or marks the header as uncorrectable. The choice depends on a two-mode machine that alternates between a correcting mode and a detect-only mode.

Four static controls shape the behaviour. One removes the fixed 0x55 offset that senders add to the check octet. One permits single-bit repair. One drops cells whose headers cannot be trusted. One replaces the outgoing check octet with a freshly computed value. The output stream carries the same bytes, possibly repaired, with a valid qualifier and a start-of-cell marker. It also carries two one-cycle flags for repaired and uncorrectable cells. The five header octets of a cell must arrive on consecutive cycles. Payload octets may have idle cycles between them.

Top module: `hec_checker`

## Requirements
- R1: While rst_ni is low, valid_o, sop_o, corr_o and err_o are 0. After reset the machine is in correcting mode, so the first single-bit header error is repaired.
- R2: The check value is the CRC with generator x^8 + x^2 + x + 1 and zero initial value, taken most significant bit first over header octets 1 to 4 (octet 1 first). A cell whose check value equals its adjusted fifth octet leaves unchanged, with corr_o and err_o both 0.
- R3: With coset_en_i = 1 the received fifth octet is XORed with 0x55 before comparison. With coset_en_i = 0 it is compared as received.
- R4: In correcting mode with corr_en_i = 1, a header with exactly one flipped bit anywhere in its 40 bits leaves with that bit restored. corr_o pulses together with its sop_o, and the machine enters detect-only mode.
- R5: In correcting mode, a header error that cannot be repaired as a single bit, or any header error while corr_en_i = 0, raises err_o, leaves the bytes unchanged, and moves the machine to detect-only mode.
- R6: In detect-only mode every errored header is uncorrectable (err_o), even a single-bit one, and the machine stays in detect-only mode.
- R7: In detect-only mode an error-free header returns the machine to correcting mode. That cell leaves unflagged.
- R8: With discard_en_i = 1, an uncorrectable cell produces no valid_o beats for any of its 53 octets. err_o still pulses in the cycle its first octet would have appeared, and the next cell is unaffected.
- R9: With regen_en_i = 1 the outgoing fifth octet is the CRC of the outgoing header octets 1 to 4, XORed with 0x55 when coset_en_i = 1.
- R10: Every forwarded octet appears on data_o exactly 5 cycles after it is taken in. sop_o marks octet 1 of a cell, and corr_o and err_o are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | 8 | Incoming cell octet |
| valid_i | input | 1 | data_i holds an octet |
| sop_i | input | 1 | data_i is octet 1 of a cell |
| coset_en_i | input | 1 | Remove the 0x55 offset from the received check octet |
| corr_en_i | input | 1 | Allow single-bit header repair |
| discard_en_i | input | 1 | Drop cells with uncorrectable headers |
| regen_en_i | input | 1 | Recompute the outgoing check octet |
| data_o | output | 8 | Outgoing cell octet |
| valid_o | output | 1 | data_o holds a forwarded octet |
| sop_o | output | 1 | data_o is octet 1 of a cell |
| corr_o | output | 1 | Pulse: this cell's header was repaired |
| err_o | output | 1 | Pulse: this cell's header is uncorrectable |

## Verification
Single-bit repair and check-octet regeneration resolve in the same decision cycle. The regenerated octet has to be built from the repaired header, not the received one. The bench provokes this by flipping one bit in a header octet, and one bit in the check octet itself, while regeneration is on. It expects the repaired header followed by the CRC of that repaired header. Discard and the uncorrectable flag also share a cycle. The bench requires err_o to pulse while valid_o stays low, and it requires no octet of the dropped cell to reach the scoreboard.

// File: rtl/hec_pkg.sv
package hec_pkg;
  localparam int unsigned OCT_W      = 8;
  localparam int unsigned HDR_OCTETS = 4;
  localparam int unsigned HDR_BITS   = OCT_W * HDR_OCTETS;
  localparam int unsigned CW_BITS    = HDR_BITS + OCT_W;
  localparam logic [OCT_W-1:0] HEC_POLY  = 8'h07;
  localparam logic [OCT_W-1:0] COSET_PAT = 8'h55;

  typedef enum logic {MODE_CORR = 1'b0, MODE_DET = 1'b1} mode_e;

  typedef struct packed {
    logic             vld;
    logic             sop;
    logic [OCT_W-1:0] dat;
  } beat_t;

  // MSB-first CRC, zero seed
  function automatic logic [OCT_W-1:0] hec_crc8(input logic [HDR_BITS-1:0] d);
    logic [OCT_W-1:0] c;
    logic             fb;
    c = '0;
    for (int i = HDR_BITS - 1; i >= 0; i--) begin
      fb = c[OCT_W-1] ^ d[i];
      c  = {c[OCT_W-2:0], 1'b0};
      if (fb) c = c ^ HEC_POLY;
    end
    return c;
  endfunction

  // syndrome produced by a lone error at codeword bit p (bit 0 = check LSB)
  function automatic logic [OCT_W-1:0] unit_syndrome(input int unsigned p);
    logic [HDR_BITS-1:0] v;
    if (p < OCT_W) return OCT_W'(1) << p;
    v = HDR_BITS'(1) << (p - OCT_W);
    return hec_crc8(v);
  endfunction
endpackage

// File: rtl/hec_crc.sv
module hec_crc
  import hec_pkg::*;
(
  input  logic [HDR_BITS-1:0] hdr_i,
  output logic [OCT_W-1:0]    crc_o
);
  always_comb crc_o = hec_crc8(hdr_i);
endmodule

// File: rtl/hec_syn_locate.sv
module hec_syn_locate
  import hec_pkg::*;
(
  input  logic [OCT_W-1:0]   syn_i,
  output logic [CW_BITS-1:0] hit_o
);
  for (genvar p = 0; p < CW_BITS; p++) begin : g_bit
    localparam logic [OCT_W-1:0] SYN_P = unit_syndrome(p);
    assign hit_o[p] = (syn_i == SYN_P);
  end
endmodule

// File: rtl/hec_mode_fsm.sv
module hec_mode_fsm
  import hec_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic decide_i,
  input  logic err_i,
  input  logic single_i,
  input  logic corr_en_i,
  input  logic discard_en_i,
  output logic fix_o,
  output logic uncorr_o,
  output logic drop_o
);
  mode_e mode_q, mode_d;

  always_comb begin
    fix_o    = decide_i && err_i && (mode_q == MODE_CORR) && corr_en_i && single_i;
    uncorr_o = decide_i && err_i && !fix_o;
    drop_o   = uncorr_o && discard_en_i;
    mode_d   = mode_q;
    if (decide_i) mode_d = err_i ? MODE_DET : MODE_CORR;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= MODE_CORR;
    else         mode_q <= mode_d;
  end

  AST_DET_NO_FIX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_DET) |-> !fix_o); // R6
  AST_ERR_ENTERS_DET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (decide_i && err_i) |=> (mode_q == MODE_DET)); // R5
  AST_CLEAN_ENTERS_CORR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (decide_i && !err_i) |=> (mode_q == MODE_CORR)); // R7
endmodule

// File: rtl/hec_checker.sv
module hec_checker
  import hec_pkg::*;
#(
  parameter int unsigned CELL_BYTES = 53
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [OCT_W-1:0] data_i,
  input  logic             valid_i,
  input  logic             sop_i,
  input  logic             coset_en_i,
  input  logic             corr_en_i,
  input  logic             discard_en_i,
  input  logic             regen_en_i,
  output logic [OCT_W-1:0] data_o,
  output logic             valid_o,
  output logic             sop_o,
  output logic             corr_o,
  output logic             err_o
);
  localparam int unsigned STAGES = HDR_OCTETS + 1;
  localparam int unsigned IDX_W  = $clog2(CELL_BYTES);

  logic [IDX_W-1:0]    cnt_q, idx;
  logic                decide;
  beat_t               pipe_q [STAGES];
  logic                drop_q, corr_q, err_q;
  logic [HDR_BITS-1:0] hdr_rx, hdr_fix;
  logic [CW_BITS-1:0]  cw_rx, cw_fix, hit;
  logic [OCT_W-1:0]    coset_pat, hec_eff, crc_rx, crc_fix, syn, hec_out;
  logic                single, fix, uncorr, drop;

  // octet position within the cell
  assign idx    = sop_i ? '0 : cnt_q;
  assign decide = valid_i && (idx == IDX_W'(HDR_OCTETS));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (valid_i) cnt_q <= (idx == IDX_W'(CELL_BYTES - 1)) ? '0 : idx + 1'b1;
  end

  // header octets sit in the delay line when the check octet arrives
  for (genvar j = 0; j < HDR_OCTETS; j++) begin : g_hdr
    assign hdr_rx[HDR_BITS-1-OCT_W*j -: OCT_W] = pipe_q[HDR_OCTETS-1-j].dat;
  end

  assign cw_rx     = {hdr_rx, data_i};
  assign coset_pat = coset_en_i ? COSET_PAT : '0;
  assign hec_eff   = data_i ^ coset_pat;

  hec_crc u_crc_rx (.hdr_i(hdr_rx), .crc_o(crc_rx));

  assign syn = crc_rx ^ hec_eff;

  hec_syn_locate u_loc (.syn_i(syn), .hit_o(hit));

  assign single = |hit;

  hec_mode_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .decide_i    (decide),
    .err_i       (syn != '0),
    .single_i    (single),
    .corr_en_i   (corr_en_i),
    .discard_en_i(discard_en_i),
    .fix_o       (fix),
    .uncorr_o    (uncorr),
    .drop_o      (drop)
  );

  assign cw_fix  = cw_rx ^ (fix ? hit : '0);
  assign hdr_fix = cw_fix[CW_BITS-1 -: HDR_BITS];

  hec_crc u_crc_fix (.hdr_i(hdr_fix), .crc_o(crc_fix));

  assign hec_out = regen_en_i ? (crc_fix ^ coset_pat) : cw_fix[OCT_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < STAGES; k++) pipe_q[k] <= '0;
      drop_q <= 1'b0;
      corr_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      pipe_q[0] <= '{vld: valid_i && (sop_i || !drop_q), sop: valid_i && sop_i, dat: data_i};
      for (int k = 1; k < STAGES; k++) pipe_q[k] <= pipe_q[k-1];
      if (decide) begin
        // rewrite the whole header in flight
        pipe_q[0] <= '{vld: !drop, sop: 1'b0, dat: hec_out};
        for (int k = 1; k < STAGES; k++) begin
          pipe_q[k].dat <= cw_fix[CW_BITS-1-OCT_W*(STAGES-1-k) -: OCT_W];
          pipe_q[k].vld <= pipe_q[k-1].vld && !drop;
        end
      end
      if (valid_i && sop_i)  drop_q <= 1'b0;
      else if (decide && drop) drop_q <= 1'b1;
      corr_q <= fix;
      err_q  <= uncorr;
    end
  end

  assign data_o  = pipe_q[STAGES-1].dat;
  assign valid_o = pipe_q[STAGES-1].vld;
  assign sop_o   = pipe_q[STAGES-1].sop && pipe_q[STAGES-1].vld;
  assign corr_o  = corr_q;
  assign err_o   = err_q;

  AST_FLAG_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(corr_o && err_o)); // R10
  AST_CORR_AT_SOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    corr_o |-> (valid_o && sop_o)); // R4
  AST_FIX_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (decide && fix) |-> ($countones(cw_fix ^ cw_rx) == 1)); // R4
  AST_DROP_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !valid_o) |=> !valid_o); // R8
endmodule

// File: tb/hec_checker_bench.sv
module hec_checker_bench;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] data_i = '0;
  logic       valid_i = 1'b0, sop_i = 1'b0;
  logic       coset_en_i = 1'b1, corr_en_i = 1'b1, discard_en_i = 1'b0, regen_en_i = 1'b0;
  logic [7:0] data_o;
  logic       valid_o, sop_o, corr_o, err_o;

  always #10 clk = ~clk;

  hec_checker u_hec_checker (
    .clk_i(clk), .rst_ni(rst_ni), .data_i(data_i), .valid_i(valid_i), .sop_i(sop_i),
    .coset_en_i(coset_en_i), .corr_en_i(corr_en_i), .discard_en_i(discard_en_i),
    .regen_en_i(regen_en_i), .data_o(data_o), .valid_o(valid_o), .sop_o(sop_o),
    .corr_o(corr_o), .err_o(err_o)
  );

  int checks = 0, errors = 0, cyc = 0;
  bit m_det = 1'b0;
  logic [8:0] dq[$];
  string      dtag[$];
  logic [2:0] eq[$];
  string      etag[$];
  int         sopq[$];

  always @(posedge clk) cyc++;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] bcrc(input logic [31:0] h);
    logic [7:0] c = 8'h00;
    for (int i = 0; i < 4; i++) begin
      c = c ^ h[31-8*i -: 8];
      for (int k = 0; k < 8; k++) c = c[7] ? ((c << 1) ^ 8'h07) : (c << 1);
    end
    return c;
  endfunction

  task automatic send_cell(input logic [31:0] hdr, input logic [39:0] flip,
                           input bit gaps, input string tag);
    logic [7:0]  cos, outhec, b;
    logic [39:0] cw, fixcw, t;
    bit good, corr, err, drop;
    cos   = coset_en_i ? 8'h55 : 8'h00;
    cw    = {hdr, bcrc(hdr) ^ cos} ^ flip;
    good  = (bcrc(cw[39:8]) == (cw[7:0] ^ cos));
    corr  = 0;
    err   = 0;
    fixcw = cw;
    if (!good) begin
      if (!m_det && corr_en_i)
        for (int p = 0; p < 40; p++) begin
          t = cw ^ (40'd1 << p);
          if (bcrc(t[39:8]) == (t[7:0] ^ cos)) begin fixcw = t; corr = 1; end
        end
      err   = !corr;
      m_det = 1'b1;
    end else m_det = 1'b0;
    drop   = err && discard_en_i;
    outhec = regen_en_i ? (bcrc(fixcw[39:8]) ^ cos) : fixcw[7:0];
    if (!drop)
      for (int i = 0; i < 53; i++) begin
        if (i < 4)       b = fixcw[39-8*i -: 8];
        else if (i == 4) b = outhec;
        else             b = 8'(hdr[7:0] + i * 3);
        dq.push_back({i == 0, b});
        dtag.push_back(tag);
      end
    if (corr || err) begin
      eq.push_back({corr, err, drop});
      etag.push_back(tag);
    end
    for (int i = 0; i < 53; i++) begin
      @(negedge clk);
      if (gaps && i > 5 && (i % 7) == 0) begin
        valid_i = 1'b0;
        @(negedge clk);
      end
      data_i  = (i < 5) ? cw[39-8*i -: 8] : 8'(hdr[7:0] + i * 3);
      valid_i = 1'b1;
      sop_i   = (i == 0);
      if (i == 0 && !drop) sopq.push_back(cyc);
    end
    @(negedge clk);
    valid_i = 1'b0;
    sop_i   = 1'b0;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_ni) begin
      if (valid_o) begin
        if (dq.size() == 0) check(0, "R10", "unexpected octet", data_o, 0);
        else begin
          automatic logic [8:0] e = dq.pop_front();
          automatic string tg = dtag.pop_front();
          check({sop_o, data_o} == e, tg, "octet", {sop_o, data_o}, e);
        end
      end
      if (valid_o && sop_o) begin
        if (sopq.size() == 0) check(0, "R10", "unexpected sop", 1, 0);
        else begin
          automatic int t0 = sopq.pop_front();
          check(cyc - t0 == 5, "R10", "latency", cyc - t0, 5);
        end
      end
      if (corr_o || err_o) begin
        if (eq.size() == 0) check(0, "R2", "unexpected flag", {corr_o, err_o}, 0);
        else begin
          automatic logic [2:0] x = eq.pop_front();
          automatic string tg = etag.pop_front();
          check({corr_o, err_o} == x[2:1], tg, "flags", {corr_o, err_o}, x[2:1]);
          if (x[0]) check(!valid_o, tg, "dropped cell visible", valid_o, 0);
          else      check(valid_o && sop_o, tg, "flag off sop", {valid_o, sop_o}, 3);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check({valid_o, sop_o, corr_o, err_o} == 4'b0, "R1", "reset outputs",
          {valid_o, sop_o, corr_o, err_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    send_cell(32'h1234_5678, 40'h00_40_00_00_00, 0, "R1 R4");
    send_cell(32'h0000_0000, 40'h0, 0, "R7");
    send_cell(32'hFFFF_FFF0, 40'h0, 0, "R2");
    send_cell(32'hA5C3_0F12, 40'h0, 0, "R2");
    coset_en_i = 1'b0;
    send_cell(32'h0102_0304, 40'h0, 0, "R3");
    send_cell(32'h0000_0000, 40'h0, 0, "R3");
    coset_en_i = 1'b1;
    send_cell(32'h0000_0000, 40'h0, 0, "R3");
    send_cell(32'h2233_4455, 40'h00_00_00_00_04, 0, "R4");
    send_cell(32'h2233_4455, 40'h0, 0, "R7");
    send_cell(32'h9ABC_DEF0, 40'h80_00_00_00_00, 0, "R4");
    send_cell(32'h1111_2222, 40'h0, 0, "R7");
    send_cell(32'h3030_4040, 40'h01_00_00_00_00, 0, "R4");
    send_cell(32'h3030_4040, 40'h00_00_10_00_00, 0, "R6");
    send_cell(32'h5050_6060, 40'h00_00_00_00_01, 0, "R6");
    send_cell(32'h5050_6060, 40'h0, 0, "R7");
    send_cell(32'h7777_8888, 40'h00_00_03_00_00, 0, "R5");
    send_cell(32'h7777_8888, 40'h0, 0, "R7");
    corr_en_i = 1'b0;
    send_cell(32'h4242_4242, 40'h00_02_00_00_00, 0, "R5");
    corr_en_i = 1'b1;
    send_cell(32'h4242_4242, 40'h0, 0, "R7");
    discard_en_i = 1'b1;
    send_cell(32'hDEAD_BEEF, 40'h00_00_00_81_00, 1, "R8");
    send_cell(32'hCAFE_0001, 40'h0, 1, "R8");
    send_cell(32'hCAFE_0002, 40'h00_00_00_08_00, 1, "R8");
    send_cell(32'hCAFE_0003, 40'h00_20_00_00_00, 1, "R8");
    send_cell(32'hCAFE_0004, 40'h0, 1, "R8");
    discard_en_i = 1'b0;
    regen_en_i   = 1'b1;
    send_cell(32'h6161_6262, 40'h00_00_00_00_20, 0, "R9");
    send_cell(32'h6161_6262, 40'h0, 0, "R9");
    send_cell(32'h6363_6464, 40'h00_04_00_00_00, 0, "R9");
    send_cell(32'h1357_9BDF, 40'h00_00_C0_00_00, 0, "R9");
    coset_en_i = 1'b0;
    send_cell(32'h2468_ACE0, 40'h0, 0, "R9");
    coset_en_i = 1'b1;
    regen_en_i = 1'b0;
    send_cell(32'h0F0F_F0F0, 40'h0, 1, "R10");
    send_cell(32'hF0F0_0F0F, 40'h0, 1, "R10");
    repeat (20) @(negedge clk);
    check(dq.size() == 0 && eq.size() == 0, "R10", "scoreboard drained",
          dq.size() + eq.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule